// File: doc/BRIEF.md
# Unipolar Stepper Gate Controller

This block is the digital core that sits between a step sequencer and a unipolar two-phase stepper output stage. It takes four active-low phase requests (two winding pairs), an enable and an active-low reset. It also receives three digitised sense signals: a chopper current-trip comparator, an overcurrent comparator and an overtemperature flag. From these it produces four active-high gate-drive enables and an active-low fault flag.

Phase requests are sampled into a register and passed through a cross-conduction interlock for each winding pair. A fixed-period chopper turns the active outputs on at the start of every period and cuts them for the rest of the period once the current trip fires. Overcurrent is blanked at the start of each period. An overcurrent event after the blanking window, or an overtemperature event at any time, sets a fault latch. The latch darkens all outputs until the block is reset. Pulling enable low darkens the outputs and freezes all internal state, so the excitation and chopper position resume exactly where they stopped.

Top module: `stepper_gate_ctrl`

## Requirements
- R1: Phase request bit `ph_n[i]` low asks for conduction on `gate[i]`. Bit 0 is winding A, bit 1 is its partner AB, bit 2 is B and bit 3 is its partner BB. A request is sampled on a rising clock edge while `en` is high and appears on `gate` after that edge.
- R2: If both members of a pair (bits 0 and 1, or bits 2 and 3) are requested together, both gates of that pair are held low until the conflict ends. The other pair is unaffected.
- R3: While `en` is low, all four `gate` bits are low, combinationally from `en`.
- R4: While `en` is low, phase requests are not sampled and the chopper counter and chopper state do not change. When `en` returns high, `gate` shows the excitation held before `en` fell.
- R5: The chopper counter is 0 in the first cycle after reset release. It advances once per enabled clock and wraps after PERIOD cycles. The wrap edge (counter at PERIOD-1) starts a new period with the outputs re-opened, even if the trip is asserted on that edge.
- R6: A high `trip` sampled on an enabled edge that is not the wrap edge forces all gates low from that edge until the next wrap edge.
- R7: Overcurrent sampled while the counter is below BLANK (the first BLANK counts of a period) has no effect.
- R8: Overcurrent sampled on an enabled edge with the counter at or above BLANK, or overtemperature sampled on any edge, sets the fault latch. After that edge `fault_n` is low and all gates are low.
- R9: Once set, the fault latch stays set until `rst_n` goes low. While `rst_n` is low, the gates are low, `fault_n` is high, the sampled requests are cleared and the counter is 0.
- R10: PERIOD equals CLK_HZ / CHOP_HZ. BLANK equals CLK_HZ * BLANK_NS / 10^9, truncated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the fault latch |
| en | input | 1 | High to run; low darkens outputs and freezes state |
| ph_n | input | 4 | Active-low phase requests {BB, B, AB, A} |
| trip | input | 1 | Chopper current-trip comparator, high when current reached set point |
| oc | input | 1 | Overcurrent comparator, high when over limit |
| ot | input | 1 | Overtemperature flag, high when hot |
| gate | output | 4 | Active-high gate-drive enables {BB, B, AB, A} |
| fault_n | output | 1 | Registered active-low fault flag (open-drain style) |

## Verification
The bench builds the block with CLK_HZ of 50 MHz, CHOP_HZ of 2 MHz and BLANK_NS of 200. This gives a 25-cycle chopper period and a 10-cycle blanking window. Several whole periods, the wrap-edge priority over the trip, and the overcurrent edge between count BLANK-1 and count BLANK can then be reached in a few hundred cycles. A 40-cycle disable spans more than one period, so a counter that kept running while disabled would re-open the outputs and be exposed.

// File: rtl/stp_pkg.sv
package stp_pkg;

  // Chopper period in system clocks.
  function automatic int chop_cycles(input int clk_hz, input int chop_hz);
    return clk_hz / chop_hz;
  endfunction

  // Blanking window in system clocks, truncated.
  function automatic int blank_cycles(input int clk_hz, input int win_ns);
    longint prod;
    prod = longint'(clk_hz) * longint'(win_ns);
    return int'(prod / 64'd1_000_000_000);
  endfunction

  // Cross-conduction guard for one winding pair: a double request yields none.
  function automatic logic [1:0] pair_guard(input logic [1:0] req);
    return (req == 2'b11) ? 2'b00 : req;
  endfunction

endpackage

// File: rtl/stp_phase_gate.sv
module stp_phase_gate #(
  parameter int NUM_PAIRS = 2,
  localparam int NPH = 2 * NUM_PAIRS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [NPH-1:0] ph_n,
  output logic [NPH-1:0] allowed
);
  import stp_pkg::*;

  logic [NPH-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  req_q <= '0;
    else if (en) req_q <= ~ph_n;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign allowed[2*p+1 -: 2] = pair_guard(req_q[2*p+1 -: 2]);
  end

  // R4: sampled requests hold while disabled
  p_req_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(req_q));

endmodule

// File: rtl/stp_chop_timer.sv
module stp_chop_timer #(
  parameter int PERIOD = 1000,
  parameter int BLANK  = 275,
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trip,
  output logic blank,
  output logic chop_off
);
  localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
  localparam logic [CW-1:0] BLANK_L = CW'(BLANK);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap  = (cnt == LAST);
  assign blank = (cnt < BLANK_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      chop_off <= 1'b0;
    end else if (en) begin
      if (wrap) begin
        cnt      <= '0;
        chop_off <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (trip) chop_off <= 1'b1;
      end
    end
  end

  // R4: timebase frozen while disabled
  p_cnt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && $stable(chop_off)));
  // R5: wrap opens a fresh period
  p_wrap_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap) |=> (cnt == '0 && !chop_off));
  // R6: trip closes the rest of the period
  p_trip_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trip && !wrap) |=> chop_off);

endmodule

// File: rtl/stp_fault_latch.sv
module stp_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic oc,
  input  logic ot,
  input  logic blank,
  output logic fault_q
);
  logic oc_hit;
  assign oc_hit = en && oc && !blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             fault_q <= 1'b0;
    else if (oc_hit || ot)  fault_q <= 1'b1;
  end

  // R7: overcurrent inside the blanking window is ignored
  p_blank_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oc && blank && !ot && !fault_q) |=> !fault_q);
  // R8: overtemperature always latches
  p_ot_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ot |=> fault_q);
  // R9: latch only clears through reset
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);

endmodule

// File: rtl/stepper_gate_ctrl.sv
module stepper_gate_ctrl #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int CHOP_HZ  = 50_000,
  parameter int BLANK_NS = 5_500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] ph_n,
  input  logic       trip,
  input  logic       oc,
  input  logic       ot,
  output logic [3:0] gate,
  output logic       fault_n
);
  import stp_pkg::*;

  localparam int PERIOD = chop_cycles(CLK_HZ, CHOP_HZ);
  localparam int BLANK  = blank_cycles(CLK_HZ, BLANK_NS);

  logic [3:0] allowed;
  logic       blank;
  logic       chop_off;
  logic       fault_q;

  stp_phase_gate #(.NUM_PAIRS(2)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .ph_n(ph_n), .allowed(allowed)
  );

  stp_chop_timer #(.PERIOD(PERIOD), .BLANK(BLANK)) u_chop (
    .clk(clk), .rst_n(rst_n), .en(en), .trip(trip),
    .blank(blank), .chop_off(chop_off)
  );

  stp_fault_latch u_fault (
    .clk(clk), .rst_n(rst_n), .en(en), .oc(oc), .ot(ot),
    .blank(blank), .fault_q(fault_q)
  );

  assign gate    = (en && !fault_q && !chop_off) ? allowed : 4'b0000;
  assign fault_n = ~fault_q;

  // R2: never both members of a pair
  p_pair_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[1]) && !(gate[2] && gate[3]));
  // R3: disabled means dark
  p_dis_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (gate == 4'b0000));
  // R8: a raised fault flag means dark
  p_fault_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (gate == 4'b0000));

endmodule

// File: tb/tb_stepper_gate_ctrl.sv
`timescale 1ns/1ps
module tb_stepper_gate_ctrl;
  localparam int CLK  = 50_000_000;
  localparam int CHOP = 2_000_000;
  localparam int WNS  = 200;
  // R10: restated independently
  localparam int P = CLK / CHOP;                       // 25
  localparam int B = (CLK / 1000) * WNS / 1_000_000;   // 10

  logic clk = 1'b0;
  logic rst_n, en, trip, oc, ot;
  logic [3:0] ph_n, gate;
  logic fault_n;
  int total = 0, bad = 0, pos = 0;
  bit done = 0;

  stepper_gate_ctrl #(.CLK_HZ(CLK), .CHOP_HZ(CHOP), .BLANK_NS(WNS)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ph_n(ph_n), .trip(trip),
    .oc(oc), .ot(ot), .gate(gate), .fault_n(fault_n)
  );

  always #10 clk = ~clk;

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b pos=%0d", req, act, exp, pos);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    if (en) pos = (pos + 1) % P;
  endtask

  task automatic do_reset();
    rst_n = 0; en = 1; ph_n = 4'hF; trip = 0; oc = 0; ot = 0;
    repeat (3) @(posedge clk);
    #1;
    chk({fault_n, gate}, 5'b1_0000, "R9 reset state");
    rst_n = 1; pos = 0;
  endtask

  task automatic t_phase();
    do_reset();
    ph_n = 4'b1110; tick(); chk({fault_n, gate}, 5'b1_0001, "R1 A only");
    ph_n = 4'b1011; tick(); chk({fault_n, gate}, 5'b1_0100, "R1 B only");
    ph_n = 4'b0101; tick(); chk({fault_n, gate}, 5'b1_1010, "R1 AB+BB");
  endtask

  task automatic t_interlock();
    do_reset();
    ph_n = 4'b1100; tick(); chk({fault_n, gate}, 5'b1_0000, "R2 A/AB clash");
    ph_n = 4'b0100; tick(); chk({fault_n, gate}, 5'b1_1000, "R2 clash plus BB");
    ph_n = 4'b0000; tick(); chk({fault_n, gate}, 5'b1_0000, "R2 all clash");
    ph_n = 4'b1110; tick(); chk({fault_n, gate}, 5'b1_0001, "R2 clash cleared");
  endtask

  task automatic t_enable();
    do_reset();
    ph_n = 4'b1110; tick();
    en = 0; #1; chk({fault_n, gate}, 5'b1_0000, "R3 disable dark");
    ph_n = 4'b1011;
    repeat (5) tick();
    chk({fault_n, gate}, 5'b1_0000, "R3 stays dark");
    en = 1; #1; chk({fault_n, gate}, 5'b1_0001, "R4 resume held A");
    tick(); chk({fault_n, gate}, 5'b1_0100, "R4 sampling resumes");
  endtask

  task automatic t_chop();
    do_reset();
    ph_n = 4'b1110; tick();
    while (pos != 5) tick();
    trip = 1; tick(); trip = 0;
    chk({fault_n, gate}, 5'b1_0000, "R6 trip closes");
    while (pos != P - 1) tick();
    chk({fault_n, gate}, 5'b1_0000, "R6 closed to period end");
    tick(); chk({fault_n, gate}, 5'b1_0001, "R5 reopen at period start");
    while (pos != P - 1) tick();
    trip = 1; tick(); trip = 0;
    chk({fault_n, gate}, 5'b1_0001, "R5 wrap beats trip");
    while (pos != 3) tick();
    trip = 1; tick(); trip = 0;
    en = 0; repeat (40) tick();
    en = 1; #1; chk({fault_n, gate}, 5'b1_0000, "R4 chopper frozen");
    while (pos != 0) tick();
    chk({fault_n, gate}, 5'b1_0001, "R4 R5 reopen after freeze");
  endtask

  task automatic t_blank();
    do_reset();
    ph_n = 4'b1110;
    oc = 1; repeat (B) tick(); oc = 0;
    chk({fault_n, gate}, 5'b1_0001, "R7 oc blanked");
    oc = 1; tick(); oc = 0;
    chk({fault_n, gate}, 5'b0_0000, "R8 oc after window");
    repeat (30) tick();
    chk({fault_n, gate}, 5'b0_0000, "R9 fault sticky");
    rst_n = 0; #1;
    chk({fault_n, gate}, 5'b1_0000, "R9 reset clears");
  endtask

  task automatic t_ot();
    do_reset();
    ph_n = 4'b1110; tick();
    ot = 1; tick(); ot = 0;
    chk({fault_n, gate}, 5'b0_0000, "R8 overtemp in window");
  endtask

  initial begin
    #(20 * 200_000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_phase();
    t_interlock();
    t_enable();
    t_chop();
    t_blank();
    t_ot();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule